// File: doc/BRIEF.md
# Programmable Countdown Interrupt Timer

This block is a per-processor countdown timer controlled over a plain 32-bit register bus (address, write strobe, write data, read strobe, read data). Software picks a clock divisor, programs an interrupt vector together with a mask bit and a mode bit, and writes a starting count. The counter then steps down once per divided clock period. When it reaches zero, the block emits a one-cycle interrupt request that carries the programmed 8-bit vector.

In one-shot mode the timer halts at zero. In periodic mode it reloads the starting count and runs again. The live count can be read at any moment. Writing a starting count of zero stops the timer. The register bus is a simple control path: a write completes on the clock edge where its strobe is high, and read data is combinational while the read strobe is high, so the bus has no back-pressure. The interrupt request is a plain pulse with no acknowledge.

Top module: `cdt_timer`

## Requirements
- R1: After reset the vector-entry register reads 0x00010000 (masked, one-shot, vector 0), the start-count and live-count registers read 0, and the divide register reads 0.
- R2: Registers sit at offset 0x320 (vector entry: bits 7:0 vector, bit 16 mask, bit 17 periodic when 1; other bits read 0), 0x380 (start count, read/write), 0x390 (live count, read-only; writes are ignored) and 0x3E0 (divide code; only bits 3, 1 and 0 are stored, and the other bits read 0). Reads of any other offset return 0.
- R3: The divide code maps as follows: 0x0 gives /2, 0x1 gives /4, 0x2 gives /8, 0x3 gives /16, 0x8 gives /32, 0x9 gives /64, 0xA gives /128 and 0xB gives /1.
- R4: A nonzero start-count write N loads the live count with N on the write edge and restarts the prescaler. The count then drops by one every D clocks, where D is the divisor, and reaches zero exactly N*D clocks after the write edge.
- R5: At divisor 1, the live count read back three clocks after a load is already below the loaded value.
- R6: On expiry, the interrupt request is high for exactly one clock, in the clock where the live count first reads zero, and carries vector bits 7:0 of the entry.
- R7: While the mask bit is set, expiry raises no request, but the counter still runs down to zero.
- R8: In one-shot mode the counter stays at zero after expiry and raises no further requests.
- R9: In periodic mode the counter reloads the start count on the clock after it reaches zero. At divisor 1 this gives one request every N+1 clocks.
- R10: Writing a start count of zero stops the timer at once, and no request follows.
- R11: A divide-code write changes the rate only at the next prescaler boundary (or at the next start-count load); the period already under way keeps the old divisor.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 12 | Register byte offset |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data (combinational; zero when not reading) |
| irq_valid | output | 1 | One-cycle interrupt request on expiry |
| irq_vector | output | 8 | Vector carried by the request |

## Verification
The hardest situation to reach from the ports is a divide-code change that arrives partway through a long prescaler period. The new code must be held back until that period closes. The stimulus starts a two-count run at /128 and rewrites the code to /1 about ten clocks later. The expiry is then expected at exactly 129 clocks after the load. An immediate switch would fire near clock 12, and a fully deferred switch would fire at clock 256, so either fault shows up as a wrong expiry time. Periodic reload is handled the same way: the bench timestamps three consecutive requests at divisor 1.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
  localparam int unsigned OFF_ENTRY = 32'h320;
  localparam int unsigned OFF_START = 32'h380;
  localparam int unsigned OFF_LIVE  = 32'h390;
  localparam int unsigned OFF_DIV   = 32'h3E0;

  localparam int unsigned MASK_BIT  = 16;
  localparam int unsigned MODE_BIT  = 17;

  // largest prescaler shift the encoding can express (/128)
  localparam int unsigned MAX_SHIFT = 7;
  localparam int unsigned SHIFT_W   = $clog2(MAX_SHIFT + 1);

  // packed divide code {bit3, bit1, bit0} -> log2 of the divisor
  function automatic logic [SHIFT_W-1:0] code_to_shift(input logic [2:0] code);
    if (code == 3'b111) return '0;
    return SHIFT_W'(code) + SHIFT_W'(1);
  endfunction
endpackage

// File: rtl/cdt_regs.sv
module cdt_regs
  import cdt_pkg::*;
#(
  parameter int unsigned AW = 12,
  parameter int unsigned DW = 32,
  parameter int unsigned CW = 32,
  parameter int unsigned VW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_we,
  input  logic [DW-1:0] bus_wdata,
  input  logic          bus_re,
  output logic [DW-1:0] bus_rdata,
  input  logic [CW-1:0] live_count,
  output logic [VW-1:0] vec_q,
  output logic          mask_q,
  output logic          periodic_q,
  output logic [CW-1:0] start_q,
  output logic [2:0]    div_code_q,
  output logic          load_stb,
  output logic [CW-1:0] load_val
);
  logic hit_entry, hit_start, hit_live, hit_div;

  assign hit_entry = (bus_addr == AW'(OFF_ENTRY));
  assign hit_start = (bus_addr == AW'(OFF_START));
  assign hit_live  = (bus_addr == AW'(OFF_LIVE));
  assign hit_div   = (bus_addr == AW'(OFF_DIV));

  assign load_stb = bus_we && hit_start;
  assign load_val = bus_wdata[CW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vec_q      <= '0;
      mask_q     <= 1'b1;
      periodic_q <= 1'b0;
      start_q    <= '0;
      div_code_q <= '0;
    end else if (bus_we) begin
      if (hit_entry) begin
        vec_q      <= bus_wdata[VW-1:0];
        mask_q     <= bus_wdata[MASK_BIT];
        periodic_q <= bus_wdata[MODE_BIT];
      end
      if (hit_start) start_q <= bus_wdata[CW-1:0];
      if (hit_div)   div_code_q <= {bus_wdata[3], bus_wdata[1], bus_wdata[0]};
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_re) begin
      if (hit_entry) begin
        bus_rdata[VW-1:0]  = vec_q;
        bus_rdata[MASK_BIT] = mask_q;
        bus_rdata[MODE_BIT] = periodic_q;
      end else if (hit_start) begin
        bus_rdata[CW-1:0] = start_q;
      end else if (hit_live) begin
        bus_rdata[CW-1:0] = live_count;
      end else if (hit_div) begin
        bus_rdata[3] = div_code_q[2];
        bus_rdata[1] = div_code_q[1];
        bus_rdata[0] = div_code_q[0];
      end
    end
  end

  // R2: a divide-register read never shows bits outside 3, 1 and 0
  a_r2_div_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && hit_div) |-> ((bus_rdata & ~DW'(32'hB)) == '0));

  // R1: the mask comes up set on the first cycle after reset
  a_r1_mask_after_reset: assert property (@(posedge clk)
    !rst_n |=> mask_q);
endmodule

// File: rtl/cdt_prescale.sv
module cdt_prescale
  import cdt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       restart,
  input  logic [2:0] div_code,
  output logic       tick
);
  localparam int unsigned PW = MAX_SHIFT;

  logic [PW-1:0]      cnt;
  logic [SHIFT_W-1:0] act_shift;
  logic [PW:0]        span;
  logic [PW-1:0]      last;

  assign span = (PW+1)'(1) << act_shift;
  assign last = span[PW-1:0] - PW'(1);
  assign tick = (cnt == last);

  // the shift in force is only replaced at a boundary or a restart
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt       <= '0;
      act_shift <= SHIFT_W'(1);
    end else if (restart || tick) begin
      cnt       <= '0;
      act_shift <= code_to_shift(div_code);
    end else begin
      cnt <= cnt + PW'(1);
    end
  end

  // R11: the phase counter never passes the boundary of the active divisor
  a_r11_phase_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= last);

  // R11: the active divisor only moves at a boundary or restart
  a_r11_shift_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && !tick) |=> $stable(act_shift));
endmodule

// File: rtl/cdt_counter.sv
module cdt_counter #(
  parameter int unsigned CW = 32,
  parameter int unsigned VW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic [CW-1:0] start_val,
  input  logic          periodic,
  input  logic          mask,
  input  logic [VW-1:0] vector,
  output logic [CW-1:0] count,
  output logic          irq_valid,
  output logic [VW-1:0] irq_vector
);
  logic running;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count      <= '0;
      running    <= 1'b0;
      irq_valid  <= 1'b0;
      irq_vector <= '0;
    end else begin
      irq_valid <= 1'b0;
      if (load) begin
        count   <= load_val;
        running <= (load_val != '0);
      end else if (running) begin
        if (count == '0) begin
          if (periodic) count <= start_val;
          else          running <= 1'b0;
        end else if (tick) begin
          count <= count - CW'(1);
          if (count == CW'(1)) begin
            irq_valid  <= !mask;
            irq_vector <= vector;
          end
        end
      end
    end
  end

  // R6: a request never lasts two cycles
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |=> !irq_valid);

  // R6: the request coincides with a zero count
  a_r6_zero_at_request: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> (count == '0));

  // R7: no request is issued when the mask was set at expiry
  a_r7_mask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> !$past(mask));

  // R4: each prescaler tick takes exactly one off a running nonzero count
  a_r4_step_one: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && running && !load && count != '0) |=> (count == $past(count) - CW'(1)));

  // R10: a zero load leaves the timer stopped at zero
  a_r10_zero_load: assert property (@(posedge clk) disable iff (!rst_n)
    (load && load_val == '0) |=> (count == '0 && !running));

  // R8: a stopped timer keeps its count until the next load
  a_r8_stopped_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !load) |=> $stable(count));
endmodule

// File: rtl/cdt_timer.sv
module cdt_timer #(
  parameter int unsigned AW = 12,
  parameter int unsigned DW = 32,
  parameter int unsigned CW = 32,
  parameter int unsigned VW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_we,
  input  logic [DW-1:0] bus_wdata,
  input  logic          bus_re,
  output logic [DW-1:0] bus_rdata,
  output logic          irq_valid,
  output logic [VW-1:0] irq_vector
);
  logic [CW-1:0] live_count;
  logic [VW-1:0] vec_q;
  logic          mask_q;
  logic          periodic_q;
  logic [CW-1:0] start_q;
  logic [2:0]    div_code_q;
  logic          load_stb;
  logic [CW-1:0] load_val;
  logic          tick;

  cdt_regs #(.AW(AW), .DW(DW), .CW(CW), .VW(VW)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_we     (bus_we),
    .bus_wdata  (bus_wdata),
    .bus_re     (bus_re),
    .bus_rdata  (bus_rdata),
    .live_count (live_count),
    .vec_q      (vec_q),
    .mask_q     (mask_q),
    .periodic_q (periodic_q),
    .start_q    (start_q),
    .div_code_q (div_code_q),
    .load_stb   (load_stb),
    .load_val   (load_val)
  );

  cdt_prescale u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (load_stb),
    .div_code (div_code_q),
    .tick     (tick)
  );

  cdt_counter #(.CW(CW), .VW(VW)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .load       (load_stb),
    .load_val   (load_val),
    .start_val  (start_q),
    .periodic   (periodic_q),
    .mask       (mask_q),
    .vector     (vec_q),
    .count      (live_count),
    .irq_valid  (irq_valid),
    .irq_vector (irq_vector)
  );

  // R6: the vector on the port matches the entry as it stood at expiry
  a_r6_vector_match: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> (irq_vector == $past(vec_q)));
endmodule

// File: tb/sim_cdt_timer.sv
module sim_cdt_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_re = 1'b0;
  logic [31:0] bus_rdata;
  logic        irq_valid;
  logic [7:0]  irq_vector;

  localparam logic [11:0] A_ENTRY = 12'h320;
  localparam logic [11:0] A_START = 12'h380;
  localparam logic [11:0] A_LIVE  = 12'h390;
  localparam logic [11:0] A_DIV   = 12'h3E0;

  // {divide code, vector, start count, expected clocks to expiry}
  localparam int NV = 8;
  localparam logic [47:0] VEC [NV] = '{
    {8'h0B, 8'h21, 16'd5, 16'd5},
    {8'h00, 8'h22, 16'd4, 16'd8},
    {8'h01, 8'h23, 16'd3, 16'd12},
    {8'h02, 8'h24, 16'd3, 16'd24},
    {8'h03, 8'h25, 16'd2, 16'd32},
    {8'h08, 8'h26, 16'd2, 16'd64},
    {8'h09, 8'h27, 16'd1, 16'd64},
    {8'h0A, 8'h28, 16'd1, 16'd128}
  };

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int irq_cnt = 0;
  int last_irq = -1;
  int prev_irq = -1;
  logic [7:0] last_vec = '0;
  int t_cyc = 0;

  cdt_timer u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .irq_valid(irq_valid), .irq_vector(irq_vector)
  );

  always #4 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  always begin
    @(posedge clk);
    #1;
    if (irq_valid) begin
      irq_cnt  = irq_cnt + 1;
      prev_irq = last_irq;
      last_irq = cyc;
      last_vec = irq_vector;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
    t_cyc = cyc;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_re = 1'b1;
    #1;
    d = bus_rdata;
    bus_re = 1'b0;
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    int n0;
    int ld;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(A_ENTRY, d); chk("R1 entry", d, 32'h00010000);
    rd(A_START, d); chk("R1 start", d, 32'h0);
    rd(A_LIVE,  d); chk("R1 live", d, 32'h0);
    rd(A_DIV,   d); chk("R1 div", d, 32'h0);
    chk("R1 irq idle", {31'h0, irq_valid}, 32'h0);

    // R2 field layout and read-only live count
    wr(A_ENTRY, 32'hFFFFFFFF); rd(A_ENTRY, d); chk("R2 entry fields", d, 32'h000300FF);
    wr(A_DIV, 32'hFFFFFFFF);   rd(A_DIV, d);   chk("R2 div bits", d, 32'h0000000B);
    wr(A_LIVE, 32'h1234);      rd(A_LIVE, d);  chk("R2 live write ignored", d, 32'h0);
    rd(12'h3F0, d); chk("R2 unmapped", d, 32'h0);

    // R3 R4 R6 R8: table of divisors, one-shot expiries
    for (int i = 0; i < NV; i++) begin
      logic [7:0]  code  = VEC[i][47:40];
      logic [7:0]  vec   = VEC[i][39:32];
      logic [15:0] n     = VEC[i][31:16];
      logic [15:0] exp_c = VEC[i][15:0];
      wr(A_DIV, {24'h0, code});
      wr(A_ENTRY, {24'h0, vec});
      n0 = irq_cnt;
      wr(A_START, {16'h0, n});
      ld = t_cyc;
      repeat (int'(exp_c) + 20) @(negedge clk);
      chk("R3 R4 expiry time", last_irq - ld, {16'h0, exp_c});
      chk("R6 vector", {24'h0, last_vec}, {24'h0, vec});
      chk("R6 R8 one pulse", irq_cnt - n0, 32'd1);
      rd(A_LIVE, d); chk("R8 stays zero", d, 32'h0);
    end

    // R5 live count moves within a few cycles at /1
    wr(A_DIV, 32'hB);
    wr(A_ENTRY, 32'h00010000);
    wr(A_START, 32'd1000);
    rd(A_LIVE, d);
    chk("R5 count moving", {31'h0, (d < 32'd1000)}, 32'h1);

    // R10 zero load stops, no request
    wr(A_ENTRY, 32'h00000044);
    n0 = irq_cnt;
    wr(A_START, 32'd10);
    wr(A_START, 32'd0);
    repeat (30) @(negedge clk);
    chk("R10 no request", irq_cnt - n0, 32'd0);
    rd(A_LIVE, d); chk("R10 stopped", d, 32'h0);

    // R7 masked expiry
    wr(A_ENTRY, 32'h00010055);
    n0 = irq_cnt;
    wr(A_START, 32'd4);
    repeat (10) @(negedge clk);
    chk("R7 masked no request", irq_cnt - n0, 32'd0);
    rd(A_LIVE, d); chk("R7 counter ran", d, 32'h0);

    // R9 periodic at /1, N=3 -> every 4 clocks
    wr(A_ENTRY, 32'h00020066);
    n0 = irq_cnt;
    wr(A_START, 32'd3);
    ld = t_cyc;
    repeat (12) @(negedge clk);
    chk("R9 pulse count", irq_cnt - n0, 32'd3);
    chk("R9 last time", last_irq - ld, 32'd11);
    chk("R9 period", last_irq - prev_irq, 32'd4);
    wr(A_START, 32'd0);

    // R11 divide change deferred to the prescaler boundary
    wr(A_ENTRY, 32'h00000077);
    wr(A_DIV, 32'hA);
    n0 = irq_cnt;
    wr(A_START, 32'd2);
    ld = t_cyc;
    repeat (9) @(negedge clk);
    wr(A_DIV, 32'hB);
    repeat (160) @(negedge clk);
    chk("R11 deferred rate", last_irq - ld, 32'd129);
    chk("R11 one pulse", irq_cnt - n0, 32'd1);

    finish_run();
  end
endmodule